// File: doc/BRIEF.md
# Strip Cluster Finder

This block turns the binary hit pattern of one silicon-strip sensor into a short list of clusters every clock cycle. A cluster is a maximal run of adjacent hit strips. The block reports it as the address of its lowest strip and its length. Before clustering, a per-strip mask removes noisy channels. After clustering, runs longer than a programmable limit are dropped. Only the lowest-addressed survivors are passed on, up to a fixed number of output slots.

The whole strip vector is handled in one pass. Small four-strip lookup tables describe the runs inside each group of four strips. A merger per group then extends a run that reaches the group's top edge with the leading runs of the next groups. A run that begins exactly at a group's low edge, while the strip just below is hit, is suppressed, because it belongs to the run below. A priority selector then packs the surviving candidates into the output slots in ascending strip order.

The block has two register stages. The masked hits are captured first, and the cluster list is registered second. When no unmasked strip is hit, the first stage keeps its contents and the output fields freeze, so idle cycles cause no toggling. The mask and the width limit are loaded through plain write ports.

Top module: `strip_cluster_finder`

## Requirements
- R1: A hit vector applied at clock edge t appears as a cluster list on the outputs right after edge t+2, and it affects no earlier output.
- R2: Each reported cluster is a maximal run of adjacent unmasked hit strips. Its position is the index of its lowest strip, and its width is the run length. A run that crosses one or two four-strip group boundaries is reported once, with its full length.
- R3: A mask write with select k and a 32-bit word covers strips 32k to 32k+31, with bit b standing for strip 32k+b. A strip whose mask bit is 1 is treated as not hit for vectors sampled at any edge after the write edge. Reset clears the whole mask.
- R4: A run whose length exceeds the width limit is discarded. A run of 8 or more strips is always discarded. The limit resets to 7, and a limit write takes effect for the list produced at the edge after the write. A limit of 0 discards every run.
- R5: At most 6 clusters are reported per cycle. Valid slots are filled from slot 0 upward with no gaps, in ascending position order, taking the lowest-positioned survivors.
- R6: The overflow flag is 1 exactly when more than 6 runs survive the width cut in that vector.
- R7: If a sampled vector has no unmasked hit, the wake output is 0 one edge later. One further edge later, all valid bits and the overflow flag are 0, and the position and width fields keep their previous values.
- R8: After reset, all valid bits, position fields, width fields, the overflow flag and the wake output are 0.
- R9: In any cycle, each valid slot's position is greater than the end of the previous slot's run (position plus width), so reported clusters never touch or overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 128 | Comparator hit per strip, bit n is strip n |
| mask_wr_en | input | 1 | Mask word write strobe |
| mask_wr_sel | input | 2 | Mask word select |
| mask_wr_data | input | 32 | Mask word, 1 removes the strip |
| thr_wr_en | input | 1 | Width limit write strobe |
| thr_wr_data | input | 3 | New width limit |
| wake_o | output | 1 | Stage one holds at least one unmasked hit |
| clu_valid_o | output | 6 | Valid bit per output slot |
| clu_pos_o | output | 42 | Slot s lowest strip at bits 7s+6:7s |
| clu_width_o | output | 18 | Slot s run length at bits 3s+2:3s |
| overflow_o | output | 1 | More than 6 clusters survived the cut |

## Verification
The bench builds the block with its default sizes: 128 strips, 6 output slots, a 3-bit width field and 32-bit mask words. With these sizes, every width limit from 0 to 7 can be written. Runs of 8 to 12 strips cover the case where a run spans three groups and saturates the merger, and ten isolated strips exceed the slot count. The four mask words let a whole-word mask silence the top quarter of the sensor. The same geometry places runs across every kind of group boundary, including strip 0 and strip 127.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int GRP = 4;

  typedef struct packed {
    logic       vld;
    logic [1:0] off;
    logic [2:0] len;
    logic       top;
  } cf_part_t;
endpackage

// File: rtl/cf_lut4.sv
module cf_lut4
  import cf_pkg::*;
(
  input  logic [GRP-1:0] bits_i,
  output cf_part_t       lo_o,
  output cf_part_t       hi_o,
  output logic [2:0]     lead_o
);
  logic [GRP:0] ext;
  logic [1:0]   nfound;
  logic [2:0]   run_len;
  logic         run_on;
  logic         lead_on;
  cf_part_t     part;

  assign ext = {bits_i, 1'b0};

  always_comb begin
    lo_o    = '0;
    hi_o    = '0;
    nfound  = '0;
    lead_o  = '0;
    lead_on = 1'b1;
    run_len = '0;
    run_on  = 1'b0;
    part    = '0;
    for (int j = 0; j < GRP; j++) begin
      if (lead_on && bits_i[j]) lead_o = lead_o + 3'd1;
      else lead_on = 1'b0;
    end
    for (int i = 0; i < GRP; i++) begin
      if (bits_i[i] && !ext[i]) begin
        run_len = '0;
        run_on  = 1'b1;
        for (int j = 0; j < GRP; j++) begin
          if (j >= i) begin
            if (run_on && bits_i[j]) run_len = run_len + 3'd1;
            else run_on = 1'b0;
          end
        end
        part.vld = 1'b1;
        part.off = 2'(i);
        part.len = run_len;
        part.top = run_on;
        if (nfound == 2'd0) lo_o = part;
        else hi_o = part;
        nfound = nfound + 2'd1;
      end
    end
  end
endmodule

// File: rtl/cf_merge.sv
module cf_merge
  import cf_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int WID_W = 3,
  parameter int G     = 0
) (
  input  cf_part_t             lo_i,
  input  cf_part_t             hi_i,
  input  logic                 prev_top_i,
  input  logic [2:0]           lead1_i,
  input  logic [2:0]           lead2_i,
  input  logic [WID_W-1:0]     thr_i,
  output logic [1:0]           vld_o,
  output logic [2*POS_W-1:0]   pos_o,
  output logic [2*WID_W-1:0]   wid_o
);
  localparam int SUM_W = 5;
  localparam logic [2:0] FULL = 3'(GRP);

  function automatic logic [SUM_W-1:0] full_len(cf_part_t p, logic [2:0] l1, logic [2:0] l2);
    logic [SUM_W-1:0] s;
    s = SUM_W'(p.len);
    if (p.top) begin
      s = s + SUM_W'(l1);
      if (l1 == FULL) s = s + SUM_W'(l2);
      if (l1 == FULL && l2 == FULL) s = '1;
    end
    return s;
  endfunction

  function automatic logic keep(cf_part_t p, logic [SUM_W-1:0] s, logic pt, logic [WID_W-1:0] thr);
    return p.vld && !(p.off == 2'd0 && pt) && (s != '0) && (s <= SUM_W'(thr));
  endfunction

  logic [SUM_W-1:0] len_lo, len_hi;

  always_comb begin
    len_lo   = full_len(lo_i, lead1_i, lead2_i);
    len_hi   = full_len(hi_i, lead1_i, lead2_i);
    vld_o[0] = keep(lo_i, len_lo, prev_top_i, thr_i);
    vld_o[1] = keep(hi_i, len_hi, 1'b0, thr_i);
    pos_o[0 +: POS_W]     = POS_W'(G * GRP) + POS_W'(lo_i.off);
    pos_o[POS_W +: POS_W] = POS_W'(G * GRP) + POS_W'(hi_i.off);
    wid_o[0 +: WID_W]     = WID_W'(len_lo);
    wid_o[WID_W +: WID_W] = WID_W'(len_hi);
  end
endmodule

// File: rtl/cf_prio.sv
module cf_prio #(
  parameter int NCAND = 64,
  parameter int NOUT  = 6,
  parameter int POS_W = 7,
  parameter int WID_W = 3
) (
  input  logic [NCAND-1:0]       vld_i,
  input  logic [NCAND*POS_W-1:0] pos_i,
  input  logic [NCAND*WID_W-1:0] wid_i,
  output logic [NOUT-1:0]        vld_o,
  output logic [NOUT*POS_W-1:0]  pos_o,
  output logic [NOUT*WID_W-1:0]  wid_o,
  output logic                   ovf_o
);
  int taken;

  always_comb begin
    vld_o = '0;
    pos_o = '0;
    wid_o = '0;
    ovf_o = 1'b0;
    taken = 0;
    for (int c = 0; c < NCAND; c++) begin
      if (vld_i[c]) begin
        if (taken >= NOUT) ovf_o = 1'b1;
        for (int s = 0; s < NOUT; s++) begin
          if (taken == s) begin
            vld_o[s]                 = 1'b1;
            pos_o[s*POS_W +: POS_W]  = pos_i[c*POS_W +: POS_W];
            wid_o[s*WID_W +: WID_W]  = wid_i[c*WID_W +: WID_W];
          end
        end
        if (taken <= NOUT) taken = taken + 1;
      end
    end
  end
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import cf_pkg::*;
#(
  parameter int N_STRIPS  = 128,
  parameter int N_OUT     = 6,
  parameter int WID_W     = 3,
  parameter int MASK_WORD = 32,
  localparam int POS_W    = $clog2(N_STRIPS),
  localparam int N_MWORD  = N_STRIPS / MASK_WORD,
  localparam int SEL_W    = (N_MWORD > 1) ? $clog2(N_MWORD) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_STRIPS-1:0]     hit_i,
  input  logic                    mask_wr_en,
  input  logic [SEL_W-1:0]        mask_wr_sel,
  input  logic [MASK_WORD-1:0]    mask_wr_data,
  input  logic                    thr_wr_en,
  input  logic [WID_W-1:0]        thr_wr_data,
  output logic                    wake_o,
  output logic [N_OUT-1:0]        clu_valid_o,
  output logic [N_OUT*POS_W-1:0]  clu_pos_o,
  output logic [N_OUT*WID_W-1:0]  clu_width_o,
  output logic                    overflow_o
);
  localparam int N_GRP  = N_STRIPS / GRP;
  localparam int N_CAND = 2 * N_GRP;

  logic [N_STRIPS-1:0] mask_q;
  logic [WID_W-1:0]    thr_q;
  logic [N_STRIPS-1:0] masked;
  logic                any_hit;
  logic [N_STRIPS-1:0] hits_q;
  logic                wake_q;
  logic [N_STRIPS:0]   hits_ext;
  logic [2:0]          lead_a [N_GRP+2];
  logic [N_CAND-1:0]       cand_v;
  logic [N_CAND*POS_W-1:0] cand_pos;
  logic [N_CAND*WID_W-1:0] cand_wid;
  logic [N_OUT-1:0]        sel_v;
  logic [N_OUT*POS_W-1:0]  sel_pos;
  logic [N_OUT*WID_W-1:0]  sel_wid;
  logic                    sel_ovf;

  // mask words, one register slice per word
  for (genvar w = 0; w < N_MWORD; w++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) mask_q[w*MASK_WORD +: MASK_WORD] <= '0;
      else if (mask_wr_en && mask_wr_sel == SEL_W'(w))
        mask_q[w*MASK_WORD +: MASK_WORD] <= mask_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) thr_q <= '1;
    else if (thr_wr_en) thr_q <= thr_wr_data;
  end

  assign masked  = hit_i & ~mask_q;
  assign any_hit = |masked;

  // stage one: hold the vector while nothing is hit
  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= any_hit;
      if (any_hit) hits_q <= masked;
    end
  end

  assign hits_ext          = {hits_q, 1'b0};
  assign lead_a[N_GRP]     = 3'd0;
  assign lead_a[N_GRP + 1] = 3'd0;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    cf_part_t   lo_w, hi_w;
    logic [2:0] lead_w;

    cf_lut4 u_lut (
      .bits_i (hits_q[g*GRP +: GRP]),
      .lo_o   (lo_w),
      .hi_o   (hi_w),
      .lead_o (lead_w)
    );
    assign lead_a[g] = lead_w;

    cf_merge #(.POS_W(POS_W), .WID_W(WID_W), .G(g)) u_merge (
      .lo_i       (lo_w),
      .hi_i       (hi_w),
      .prev_top_i (hits_ext[g*GRP]),
      .lead1_i    (lead_a[g+1]),
      .lead2_i    (lead_a[g+2]),
      .thr_i      (thr_q),
      .vld_o      (cand_v[2*g +: 2]),
      .pos_o      (cand_pos[2*g*POS_W +: 2*POS_W]),
      .wid_o      (cand_wid[2*g*WID_W +: 2*WID_W])
    );
  end

  cf_prio #(.NCAND(N_CAND), .NOUT(N_OUT), .POS_W(POS_W), .WID_W(WID_W)) u_prio (
    .vld_i (cand_v),
    .pos_i (cand_pos),
    .wid_i (cand_wid),
    .vld_o (sel_v),
    .pos_o (sel_pos),
    .wid_o (sel_wid),
    .ovf_o (sel_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clu_valid_o <= '0;
      clu_pos_o   <= '0;
      clu_width_o <= '0;
      overflow_o  <= 1'b0;
    end else if (wake_q) begin
      clu_valid_o <= sel_v;
      clu_pos_o   <= sel_pos;
      clu_width_o <= sel_wid;
      overflow_o  <= sel_ovf;
    end else begin
      clu_valid_o <= '0;
      overflow_o  <= 1'b0;
    end
  end

  assign wake_o = wake_q;

  // ---------------- assertions ----------------
  assert_wake_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (hits_q != '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wake_q |=> (clu_valid_o == '0 && !overflow_o && $stable(clu_pos_o) && $stable(clu_width_o)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> (&clu_valid_o));

  for (genvar s = 0; s < N_OUT; s++) begin : g_chk
    assert_width_cut_R4: assert property (@(posedge clk) disable iff (rst)
      clu_valid_o[s] |-> (clu_width_o[s*WID_W +: WID_W] != '0 &&
                          clu_width_o[s*WID_W +: WID_W] <= $past(thr_q)));
    if (s > 0) begin : g_pair
      assert_packed_slots_R5: assert property (@(posedge clk) disable iff (rst)
        clu_valid_o[s] |-> clu_valid_o[s-1]);
      assert_ascending_R9: assert property (@(posedge clk) disable iff (rst)
        clu_valid_o[s] |-> ({1'b0, clu_pos_o[s*POS_W +: POS_W]} >
          ({1'b0, clu_pos_o[(s-1)*POS_W +: POS_W]} + (POS_W+1)'(clu_width_o[(s-1)*WID_W +: WID_W]))));
    end
  end
endmodule

// File: tb/strip_cluster_finder_tb.sv
module strip_cluster_finder_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] hit_i;
  logic         mask_wr_en;
  logic [1:0]   mask_wr_sel;
  logic [31:0]  mask_wr_data;
  logic         thr_wr_en;
  logic [2:0]   thr_wr_data;
  logic         wake_o;
  logic [5:0]   clu_valid_o;
  logic [41:0]  clu_pos_o;
  logic [17:0]  clu_width_o;
  logic         overflow_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  logic [127:0] mask_m;
  int           thr_m;
  logic [127:0] s1_hits;
  logic         s1_wake;
  logic [5:0]   e_v;
  logic [41:0]  e_pos;
  logic [17:0]  e_wid;
  logic         e_ovf;
  logic         e_wake;
  logic [5:0]   n_v;
  logic [41:0]  n_pos;
  logic [17:0]  n_wid;
  logic         n_ovf;

  always #2.5 clk = ~clk;

  strip_cluster_finder u_dut (
    .clk(clk), .rst(rst), .hit_i(hit_i),
    .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .wake_o(wake_o), .clu_valid_o(clu_valid_o), .clu_pos_o(clu_pos_o),
    .clu_width_o(clu_width_o), .overflow_o(overflow_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [127:0] rng(int lo, int hi);
    logic [127:0] v = '0;
    for (int i = lo; i <= hi; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic model_list(input logic [127:0] h, input int thr);
    int n = 0;
    n_v = '0; n_pos = '0; n_wid = '0;
    for (int i = 0; i < 128; i++) begin
      if (h[i] && (i == 0 || !h[(i > 0) ? i-1 : 0])) begin
        int len = 0;
        int j = i;
        while (j < 128 && h[j]) begin len++; j++; end
        if (len <= thr && len <= 7) begin
          if (n < 6) begin
            n_v[n] = 1'b1;
            n_pos[n*7 +: 7] = 7'(i);
            n_wid[n*3 +: 3] = 3'(len);
          end
          n++;
        end
      end
    end
    n_ovf = (n > 6);
  endtask

  task automatic check_outputs(input string tag);
    checks++;
    if (clu_valid_o !== e_v || clu_pos_o !== e_pos || clu_width_o !== e_wid ||
        overflow_o !== e_ovf || wake_o !== e_wake) begin
      fails++;
      $display("FAIL %s: valid=%b pos=%h wid=%h ovf=%b wake=%b expected valid=%b pos=%h wid=%h ovf=%b wake=%b",
               tag, clu_valid_o, clu_pos_o, clu_width_o, overflow_o, wake_o,
               e_v, e_pos, e_wid, e_ovf, e_wake);
    end
  endtask

  task automatic step(input logic [127:0] h, input bit mw, input int msel,
                      input logic [31:0] mdata, input bit tw, input int tdata,
                      input string tag);
    logic [127:0] nm;
    check_outputs(tag);
    hit_i        = h;
    mask_wr_en   = mw;
    mask_wr_sel  = 2'(msel);
    mask_wr_data = mdata;
    thr_wr_en    = tw;
    thr_wr_data  = 3'(tdata);
    if (s1_wake) model_list(s1_hits, thr_m);
    else begin
      n_v = '0; n_ovf = 1'b0; n_pos = e_pos; n_wid = e_wid;
    end
    nm = h & ~mask_m;
    @(posedge clk);
    if (mw) mask_m[msel*32 +: 32] = mdata;
    if (tw) thr_m = tdata;
    e_v = n_v; e_pos = n_pos; e_wid = n_wid; e_ovf = n_ovf;
    e_wake  = (nm != '0);
    s1_wake = (nm != '0);
    if (nm != '0) s1_hits = nm;
    @(negedge clk);
  endtask

  task automatic go(input logic [127:0] h, input string tag);
    step(h, 1'b0, 0, 32'h0, 1'b0, 0, tag);
  endtask

  initial begin
    logic [127:0] h;
    rst = 1'b1; hit_i = '0; mask_wr_en = 0; mask_wr_sel = 0; mask_wr_data = 0;
    thr_wr_en = 0; thr_wr_data = 0;
    mask_m = '0; thr_m = 7; s1_hits = '0; s1_wake = 0;
    e_v = '0; e_pos = '0; e_wid = '0; e_ovf = 0; e_wake = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_outputs("R8");

    // latency of a single pulse
    go(rng(5, 5), "R1");
    go('0, "R1"); go('0, "R1"); go('0, "R1");

    // runs across group boundaries
    go(rng(3, 4), "R2");
    go(rng(2, 8), "R2");
    go(rng(124, 127) | rng(0, 0), "R2");
    go(rng(60, 66) | rng(70, 71), "R2");
    go(rng(9, 11) | rng(12, 12) | rng(100, 102), "R2");
    go('0, "R2"); go('0, "R2");

    // width cut
    go(rng(20, 27) | rng(40, 40), "R4");
    go(rng(20, 31) | rng(50, 56), "R4");
    step(rng(1, 1) | rng(4, 5) | rng(8, 10), 1'b0, 0, 0, 1'b1, 2, "R4");
    go(rng(1, 1) | rng(4, 5) | rng(8, 10), "R4");
    step(rng(30, 30), 1'b0, 0, 0, 1'b1, 0, "R4");
    go(rng(30, 30) | rng(90, 91), "R4");
    step(rng(44, 50), 1'b0, 0, 0, 1'b1, 7, "R4");
    go(rng(44, 50), "R4");
    go('0, "R4"); go('0, "R4");

    // mask
    step(rng(4, 6), 1'b1, 0, 32'h0000_0020, 1'b0, 0, "R3");
    go(rng(4, 6), "R3");
    step(rng(96, 99), 1'b1, 3, 32'hFFFF_FFFF, 1'b0, 0, "R3");
    go(rng(96, 127), "R3");
    go(rng(96, 127) | rng(64, 65), "R3");
    step('0, 1'b1, 3, 32'h0, 1'b0, 0, "R3");
    step('0, 1'b1, 0, 32'h0, 1'b0, 0, "R3");
    go(rng(4, 6) | rng(120, 121), "R3");

    // slot limit and overflow
    h = '0; for (int k = 0; k < 10; k++) h[k*10] = 1'b1;
    go(h, "R5");
    h = '0; for (int k = 0; k < 6; k++) h[k*20+3] = 1'b1;
    go(h, "R6");
    h = '0; for (int k = 0; k < 7; k++) h[k*18+1] = 1'b1;
    go(h, "R6");
    h = '0; for (int k = 0; k < 7; k++) h[k*18+1] = 1'b1;
    go(h | rng(0, 0), "R6");

    // idle hold
    go('0, "R7"); go('0, "R7"); go('0, "R7");
    go(rng(127, 127), "R7");
    go('0, "R7"); go('0, "R7"); go('0, "R7");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      for (int w = 0; w < 4; w++) begin
        h[w*32 +: 32] = $urandom & $urandom;
        if (k % 3 == 0) h[w*32 +: 32] = h[w*32 +: 32] & $urandom;
        if (k % 5 == 1) h[w*32 +: 32] = h[w*32 +: 32] | $urandom;
      end
      if (k % 11 == 0) h = '0;
      if (k % 17 == 0)
        step(h, 1'b0, 0, 0, 1'b1, int'($urandom % 8), "R9");
      else if (k % 29 == 0)
        step(h, 1'b1, int'($urandom % 4), $urandom & $urandom & $urandom, 1'b0, 0, "R9");
      else
        go(h, "R9");
    end
    go('0, "R9"); go('0, "R9"); go('0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule